// File: doc/BRIEF.md
# Instruction Prefetch Queue with Store Snooping

This block sits between instruction fetch and decode. Fetch pushes 32-bit instruction words, each tagged with its linear and its physical address, into an eight-entry first-in first-out queue. Decode pops them in order. Each fetch also marks the matching line of a small direct-mapped array of resident instruction lines as valid.

Every data store is checked in two separate ways, so that code which rewrites itself is never run stale. The store's physical address is looked up in the line array. A resident line that matches is dropped. The store's linear address is compared, at 4-byte grain, against every word held in the queue and against a word being pushed in the same cycle. Any match empties the whole queue.

A taken jump also empties the queue. A serializing event empties the queue and clears every resident line. Each time the queue is emptied, a one-cycle flush pulse is raised so that fetch can restart from the current program counter. Translation, memory and the decoder lie outside the block: both address forms arrive on the ports.

Top module: `pfq_snoop_top`

## Requirements
- R1: After reset the queue is empty (`head_valid`=0, `q_count`=0, `q_full`=0), `flush` is 0 and all of `line_valid` is 0.
- R2: Pushed words leave in push order. A push in cycle t appears in `q_count` (and at the head, if the queue was empty) after the clock edge that ends cycle t. `head_*` always shows the oldest entry.
- R3: The queue holds 8 entries. A push while full is dropped unless a pop happens in the same cycle, and a pop while empty is ignored. `q_full` is 1 exactly when `q_count` is 8.
- R4: Each cycle with `fetch_valid`=1 marks line index `fetch_phys[8:5]` valid, with tag `fetch_phys[31:9]`. This happens whether or not the word enters the queue, and it is visible after the next edge.
- R5: A store (`st_valid`=1) whose `st_phys` has the index of a valid line and that line's tag clears that line's `line_valid` bit after the next edge. A store to the same index with a different tag leaves the line alone. The physical check alone never empties the queue. When a fill and such a store hit the same line in one cycle, the store wins.
- R6: A store whose `st_linear[31:2]` equals `linear[31:2]` of any queued word, or of a word pushed in the same cycle, empties the queue. The match uses the linear address only, so a match of the physical address alone does not empty the queue.
- R7: `jump_taken`=1 empties the queue.
- R8: `serialize`=1 empties the queue and clears every `line_valid` bit, and a fill in the same cycle is dropped.
- R9: Whenever the queue is emptied, `q_count` is 0 and `flush` is 1 after the next edge. `flush` stays high for exactly one cycle unless another emptying event follows. A push in the same cycle as an emptying event is dropped.
- R10: With `st_valid`=0, the store addresses have no effect on the queue, the lines or `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Push strobe from fetch |
| fetch_word | input | 32 | Instruction word to push |
| fetch_linear | input | 32 | Linear address of the word |
| fetch_phys | input | 32 | Physical address of the word |
| pop | input | 1 | Decode takes the head entry |
| st_valid | input | 1 | Data store strobe |
| st_linear | input | 32 | Linear address of the store |
| st_phys | input | 32 | Physical address of the store |
| serialize | input | 1 | Serializing event pulse |
| jump_taken | input | 1 | Taken jump pulse |
| head_valid | output | 1 | Queue not empty |
| head_word | output | 32 | Oldest queued word |
| head_linear | output | 32 | Linear address of the oldest word |
| head_phys | output | 32 | Physical address of the oldest word |
| q_count | output | 4 | Number of queued words |
| q_full | output | 1 | Queue holds 8 words |
| line_valid | output | 16 | Valid bit per instruction line |
| flush | output | 1 | One-cycle pulse: queue was emptied |

## Verification
Every result of this block is due one edge after its stimulus. Pushes, pops, line fills, line drops, emptying and the flush pulse all appear together after the edge that sampled the inputs, and nothing is due later. The bench drives inputs 1 ns after an edge, then advances a behavioural model at the next edge from those same inputs, and compares all outputs 1 ns after that edge. Each comparison therefore lands on the cycle in which the result is due. Directed checks then test the cycle after each event for the single-cycle width of `flush` and for the ignored cases.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [ADDR_W-1:0] lin;
        logic [ADDR_W-1:0] phys;
    } pfq_entry_t;
endpackage

// File: rtl/pfq_queue.sv
module pfq_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int GRAIN_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  pfq_entry_t                    push_ent_i,
    input  logic                          pop_i,
    input  logic                          flush_i,
    input  logic                          st_valid_i,
    input  logic [ADDR_W-1:0]             st_lin_i,
    output logic                          lin_hit_o,
    output pfq_entry_t                    head_o,
    output logic                          head_valid_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          full_o
);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH+1);
    localparam int GRAIN_W = $clog2(GRAIN_BYTES);

    typedef struct packed {
        pfq_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       rd;
        logic [PTR_W-1:0]       wr;
        logic [CNT_W-1:0]       count;
    } qstate_t;

    qstate_t    st_q, st_d;
    logic       pop_ok, push_ok;
    logic [DEPTH-1:0] occ, match;
    logic       push_match;

    // occupancy and linear-address compare per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PTR_W-1:0] rel;
        assign rel      = PTR_W'(g) - st_q.rd;
        assign occ[g]   = (CNT_W'(rel) < st_q.count);
        assign match[g] = (st_q.mem[g].lin[ADDR_W-1:GRAIN_W] == st_lin_i[ADDR_W-1:GRAIN_W]);
    end

    assign pop_ok     = pop_i && (st_q.count != '0);
    assign push_ok    = push_i && ((st_q.count != CNT_W'(DEPTH)) || pop_ok);
    assign push_match = push_ok && (push_ent_i.lin[ADDR_W-1:GRAIN_W] == st_lin_i[ADDR_W-1:GRAIN_W]);
    assign lin_hit_o  = st_valid_i && ((|(occ & match)) || push_match);

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.rd    = '0;
            st_d.wr    = '0;
            st_d.count = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_ent_i;
                st_d.wr           = st_q.wr + 1'b1;
            end
            if (pop_ok) begin
                st_d.rd = st_q.rd + 1'b1;
            end
            st_d.count = st_q.count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o       = st_q.mem[st_q.rd];
    assign head_valid_o = (st_q.count != '0);
    assign count_o      = st_q.count;
    assign full_o       = (st_q.count == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH)); // R3
    AST_POP_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0 && !push_i && !flush_i) |=> (st_q.count == '0)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.count == '0)); // R9
endmodule

// File: rtl/pfq_line_array.sv
module pfq_line_array
    import pfq_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_i,
    input  logic [ADDR_W-1:0]     fill_phys_i,
    input  logic                  st_valid_i,
    input  logic [ADDR_W-1:0]     st_phys_i,
    input  logic                  clear_i,
    output logic [NUM_LINES-1:0]  valid_o
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        logic [NUM_LINES-1:0]            valid;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
    } lstate_t;

    lstate_t          st_q, st_d;
    logic [IDX_W-1:0] fill_idx, st_idx;
    logic [TAG_W-1:0] fill_tag, st_tag;

    assign fill_idx = fill_phys_i[OFF_W +: IDX_W];
    assign fill_tag = fill_phys_i[ADDR_W-1 -: TAG_W];
    assign st_idx   = st_phys_i[OFF_W +: IDX_W];
    assign st_tag   = st_phys_i[ADDR_W-1 -: TAG_W];

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.valid = '0;
        end else begin
            if (fill_i) begin
                st_d.valid[fill_idx] = 1'b1;
                st_d.tag[fill_idx]   = fill_tag;
            end
            // store applied after fill: a store to a line filled now still drops it
            if (st_valid_i && st_d.valid[st_idx] && (st_d.tag[st_idx] == st_tag)) begin
                st_d.valid[st_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;

    AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !clear_i && !st_valid_i) |=> valid_o[$past(fill_idx)]); // R4
    AST_STORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_q.valid[st_idx] && st_q.tag[st_idx] == st_tag)
            |=> !valid_o[$past(st_idx)]); // R5
endmodule

// File: rtl/pfq_flush_ctrl.sv
module pfq_flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic serialize_i,
    input  logic jump_i,
    input  logic snoop_hit_i,
    output logic flush_now_o,
    output logic flush_pulse_o
);
    typedef struct packed {
        logic pulse;
    } fstate_t;

    fstate_t st_q, st_d;

    assign flush_now_o = serialize_i || jump_i || snoop_hit_i;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = flush_now_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_pulse_o = st_q.pulse;

    AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> flush_pulse_o); // R7
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_now_o |=> !flush_pulse_o); // R9
endmodule

// File: rtl/pfq_snoop_top.sv
module pfq_snoop_top
    import pfq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int NUM_LINES   = 16,
    parameter int LINE_BYTES  = 32,
    parameter int GRAIN_BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fetch_valid,
    input  logic [WORD_W-1:0]          fetch_word,
    input  logic [ADDR_W-1:0]          fetch_linear,
    input  logic [ADDR_W-1:0]          fetch_phys,
    input  logic                       pop,
    input  logic                       st_valid,
    input  logic [ADDR_W-1:0]          st_linear,
    input  logic [ADDR_W-1:0]          st_phys,
    input  logic                       serialize,
    input  logic                       jump_taken,
    output logic                       head_valid,
    output logic [WORD_W-1:0]          head_word,
    output logic [ADDR_W-1:0]          head_linear,
    output logic [ADDR_W-1:0]          head_phys,
    output logic [$clog2(DEPTH+1)-1:0] q_count,
    output logic                       q_full,
    output logic [NUM_LINES-1:0]       line_valid,
    output logic                       flush
);
    pfq_entry_t push_ent, head_ent;
    logic       lin_hit, flush_now;

    assign push_ent = '{word: fetch_word, lin: fetch_linear, phys: fetch_phys};

    pfq_queue #(.DEPTH(DEPTH), .GRAIN_BYTES(GRAIN_BYTES)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(fetch_valid), .push_ent_i(push_ent), .pop_i(pop),
        .flush_i(flush_now), .st_valid_i(st_valid), .st_lin_i(st_linear),
        .lin_hit_o(lin_hit), .head_o(head_ent), .head_valid_o(head_valid),
        .count_o(q_count), .full_o(q_full)
    );

    pfq_line_array #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .fill_i(fetch_valid), .fill_phys_i(fetch_phys),
        .st_valid_i(st_valid), .st_phys_i(st_phys),
        .clear_i(serialize), .valid_o(line_valid)
    );

    pfq_flush_ctrl u_flush (
        .clk(clk), .rst_n(rst_n),
        .serialize_i(serialize), .jump_i(jump_taken), .snoop_hit_i(lin_hit),
        .flush_now_o(flush_now), .flush_pulse_o(flush)
    );

    assign head_word   = head_ent.word;
    assign head_linear = head_ent.lin;
    assign head_phys   = head_ent.phys;

    AST_SNOOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        lin_hit |=> (flush && !head_valid)); // R6
    AST_SER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        serialize |=> (line_valid == '0 && flush)); // R8
endmodule

// File: tb/pfq_snoop_top_tb_top.sv
`timescale 1ns/100ps
module pfq_snoop_top_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_valid = 0, pop = 0, st_valid = 0, serialize = 0, jump_taken = 0;
    logic [31:0] fetch_word = 0, fetch_linear = 0, fetch_phys = 0, st_linear = 0, st_phys = 0;
    logic head_valid, q_full, flush;
    logic [31:0] head_word, head_linear, head_phys;
    logic [3:0] q_count;
    logic [15:0] line_valid;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    logic [31:0] mw[$], ml[$], mp[$];
    bit          mlv[16];
    logic [22:0] mtag[16];
    bit          mflush = 0;

    always #2.5 clk = ~clk;

    pfq_snoop_top dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_linear(fetch_linear), .fetch_phys(fetch_phys), .pop(pop),
        .st_valid(st_valid), .st_linear(st_linear), .st_phys(st_phys),
        .serialize(serialize), .jump_taken(jump_taken), .head_valid(head_valid),
        .head_word(head_word), .head_linear(head_linear), .head_phys(head_phys),
        .q_count(q_count), .q_full(q_full), .line_valid(line_valid), .flush(flush)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_update();
        bit pop_ok, push_ok, hit, fl;
        int idx;
        pop_ok  = pop && (mw.size() > 0);
        push_ok = fetch_valid && (mw.size() < 8 || pop_ok);
        hit = 0;
        if (st_valid) begin
            foreach (ml[i]) if (ml[i][31:2] == st_linear[31:2]) hit = 1;
            if (push_ok && fetch_linear[31:2] == st_linear[31:2]) hit = 1;
        end
        fl = serialize || jump_taken || hit;
        mflush = fl;
        if (fl) begin
            mw.delete(); ml.delete(); mp.delete();
        end else begin
            if (pop_ok) begin void'(mw.pop_front()); void'(ml.pop_front()); void'(mp.pop_front()); end
            if (push_ok) begin mw.push_back(fetch_word); ml.push_back(fetch_linear); mp.push_back(fetch_phys); end
        end
        if (serialize) begin
            for (int i = 0; i < 16; i++) mlv[i] = 0;
        end else begin
            if (fetch_valid) begin
                idx = int'(fetch_phys[8:5]);
                mlv[idx] = 1; mtag[idx] = fetch_phys[31:9];
            end
            idx = int'(st_phys[8:5]);
            if (st_valid && mlv[idx] && mtag[idx] == st_phys[31:9]) mlv[idx] = 0;
        end
    endtask

    task automatic compare();
        logic [15:0] lv;
        for (int i = 0; i < 16; i++) lv[i] = mlv[i];
        chk(q_count == 4'(mw.size()), "R2 count", 32'(q_count), 32'(mw.size()));
        chk(head_valid == (mw.size() > 0), "R2 head_valid", 32'(head_valid), 32'(mw.size() > 0));
        if (mw.size() > 0) begin
            chk(head_word == mw[0], "R2 head_word", head_word, mw[0]);
            chk(head_linear == ml[0], "R2 head_linear", head_linear, ml[0]);
            chk(head_phys == mp[0], "R2 head_phys", head_phys, mp[0]);
        end
        chk(q_full == (mw.size() == 8), "R3 full", 32'(q_full), 32'(mw.size() == 8));
        chk(line_valid == lv, "R4 line_valid", 32'(line_valid), 32'(lv));
        chk(flush == mflush, "R9 flush", 32'(flush), 32'(mflush));
    endtask

    task automatic idle();
        fetch_valid = 0; pop = 0; st_valid = 0; serialize = 0; jump_taken = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare();
        idle();
    endtask

    task automatic push(input logic [31:0] w, input logic [31:0] l, input logic [31:0] p);
        fetch_valid = 1; fetch_word = w; fetch_linear = l; fetch_phys = p;
    endtask

    task automatic store(input logic [31:0] l, input logic [31:0] p);
        st_valid = 1; st_linear = l; st_phys = p;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mlv[i] = 0; mtag[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(!head_valid && q_count == 0 && !q_full, "R1 empty", 32'(q_count), 0);
        chk(!flush, "R1 flush", 32'(flush), 0);
        chk(line_valid == 0, "R1 lines", 32'(line_valid), 0);

        // R2 order: three words
        for (int i = 0; i < 3; i++) begin
            push(32'hA000_0000 + i, 32'h100 + 4*i, 32'h1000 + 32*i);
            step();
        end
        chk(head_word == 32'hA000_0000, "R2 first out", head_word, 32'hA000_0000);
        for (int i = 0; i < 3; i++) begin pop = 1; step(); end
        // R3 pop while empty ignored
        pop = 1; step();
        chk(q_count == 0, "R3 pop empty", 32'(q_count), 0);

        // R3 fill past depth
        for (int i = 0; i < 9; i++) begin
            push(32'hB000_0000 + i, 32'h200 + 4*i, 32'h2000 + 32*i);
            step();
        end
        chk(q_count == 8 && q_full, "R3 capped at 8", 32'(q_count), 8);
        chk(head_word == 32'hB000_0000, "R3 dropped push", head_word, 32'hB000_0000);
        // R3 push with pop while full
        push(32'hB000_0010, 32'h300, 32'h2200); pop = 1; step();
        chk(q_count == 8, "R3 push+pop full", 32'(q_count), 8);

        // R6 physical-only match of a queued word: no flush; R5 line dropped
        store(32'h7000, 32'h2000 + 32*3); step();
        chk(!flush && q_count == 8, "R6 phys only no flush", 32'(q_count), 8);
        chk(!line_valid[3], "R5 line dropped", 32'(line_valid), 0);
        // R5 same index, other tag: line stays
        store(32'h7000, 32'h2000 + 32*4 + 32'h200); step();
        chk(line_valid[4], "R5 tag mismatch kept", 32'(line_valid[4]), 1);
        // R10 st_valid low with matching linear
        st_linear = 32'h208; st_phys = 32'h2000 + 32*5; step();
        chk(!flush && q_count == 8 && line_valid[5], "R10 no strobe", 32'(q_count), 8);

        // R6 linear hit on a queued word (byte inside the grain)
        store(32'h20B, 32'h9000); step();
        chk(flush && q_count == 0, "R6 lin hit flush", 32'(q_count), 0);
        step();
        chk(!flush, "R9 pulse one cycle", 32'(flush), 0);

        // R7 jump flush
        push(32'hC000_0000, 32'h400, 32'h3000); step();
        push(32'hC000_0001, 32'h404, 32'h3020); step();
        jump_taken = 1; step();
        chk(flush && q_count == 0, "R7 jump flush", 32'(q_count), 0);

        // R9 push in same cycle as jump dropped
        push(32'hC000_0002, 32'h408, 32'h3040); jump_taken = 1; step();
        chk(q_count == 0 && flush, "R9 push loses", 32'(q_count), 0);

        // R6 store hitting same-cycle push
        push(32'hD000_0000, 32'h500, 32'h4000); store(32'h502, 32'h9100); step();
        chk(q_count == 0 && flush, "R6 same-cycle push", 32'(q_count), 0);

        // R5 fill and store on same line in one cycle: store wins
        push(32'hD000_0001, 32'h600, 32'h5000); store(32'h9000, 32'h5004); step();
        chk(!line_valid[0] && q_count == 1, "R5 store wins fill", 32'(line_valid), 0);

        // R8 serialize
        push(32'hE000_0000, 32'h700, 32'h6020); step();
        serialize = 1; push(32'hE000_0001, 32'h704, 32'h6040); step();
        chk(line_valid == 0 && q_count == 0 && flush, "R8 serialize", 32'(line_valid), 0);

        // mixed traffic
        for (int i = 0; i < 40; i++) begin
            if (i % 3 != 2) push(32'hF000_0000 + i, 32'h800 + 4*i, 32'h7000 + 32*i);
            if (i % 4 == 3) pop = 1;
            if (i % 11 == 10) store(32'h800 + 4*(i-2), 32'h7000 + 32*(i-1));
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule